// File: doc/BRIEF.md
# Running Median Filter with Fixed Sample Slots

This block computes the running median of a stream of fixed-width samples over a sliding window of odd length N. It accepts at most one sample per clock cycle. Each accepted sample is written once into one of N storage slots and stays there until it becomes the oldest sample in the window. A single circulating one-hot pointer marks the slot to overwrite, so the new sample always replaces the oldest one.

The samples never move. The ordering of the window is kept as a small rank value per slot. When a sample is accepted, only these ranks change: the ranks above the departing sample shift down, and the ranks at or above the arriving sample shift up. The arriving sample takes a rank equal to the number of remaining samples that order below it. Equal values are ordered by slot index, so the ranks always hold every value from 0 to N-1 exactly once. The median is the slot whose rank is (N-1)/2. It is selected by a one-hot multiplexer and registered.

The filter suits impulse-noise removal on wide samples. Keeping the data registers still, and toggling only the narrow rank fields, reduces switching activity.

Top module: `tokring_median`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_median` become 0, and the window is taken to hold N samples of value 0.
- R2: `out_valid` equals the value of `in_valid` one cycle earlier.
- R3: When `in_valid` is high, the median of the last N accepted samples, with the new sample included, appears on `out_median` on the next cycle. The median is the element at index (N-1)/2 of that set sorted in ascending order.
- R4: Windows that contain repeated values give the same median as R3. Equal values are ordered by slot index, so the per-slot ranks stay a permutation of 0 to N-1.
- R5: A cycle with `in_valid` low leaves both the window contents and `out_median` unchanged.
- R6: A stored sample is never modified until its slot is overwritten by a new sample.
- R7: The write pointer moves one slot per accepted sample and wraps from slot N-1 to slot 0. Each new sample therefore replaces the oldest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | W | Incoming sample |
| out_valid | output | 1 | `out_median` was updated at the last edge |
| out_median | output | W | Median of the current window |

## Verification
Every accepted sample produces its median and its valid flag exactly one clock edge later, because a single output register sits between input and output. A cycle without a sample must leave the previous median in place. The bench drives each input at a falling edge. At the next falling edge it compares the outputs against a window model that is updated at the moment the input is driven, so every comparison falls in the cycle where the result is due. The sweeps cover all triples of a 3-bit sample alphabet, constant and monotonic streams, and a long pseudo-random stream with gaps. This forces the write pointer to wrap many times and produces every tie pattern.

// File: rtl/tokring_median.sv
`timescale 1ns/1ps
module tokring_median #(
  parameter int N = 7,
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic         out_valid,
  output logic [W-1:0] out_median
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam logic [RW-1:0] MIDR = RW'((N - 1) / 2);

  logic [W-1:0]  data_q [N];
  logic [RW-1:0] rank_q [N];
  logic [N-1:0]  tok_q;

  logic [W-1:0]  data_d [N];
  logic [RW-1:0] rank_d [N];
  logic [N-1:0]  low_mask;
  logic [N-1:0]  below_new;
  logic [RW-1:0] old_rank;
  logic [RW-1:0] new_rank;
  logic [W-1:0]  med_d;

  assign low_mask = tok_q - 1'b1;

  always_comb begin
    old_rank = '0;
    new_rank = '0;
    for (int j = 0; j < N; j++) begin
      if (tok_q[j]) old_rank = old_rank | rank_q[j];
      below_new[j] = !tok_q[j] &&
                     ((data_q[j] < in_sample) || (data_q[j] == in_sample && low_mask[j]));
      new_rank = new_rank + RW'(below_new[j]);
    end
  end

  always_comb begin
    med_d = '0;
    for (int j = 0; j < N; j++) begin
      data_d[j] = tok_q[j] ? in_sample : data_q[j];
      if (tok_q[j])
        rank_d[j] = new_rank;
      else
        rank_d[j] = rank_q[j] - RW'(rank_q[j] > old_rank) + RW'(!below_new[j]);
      if (rank_d[j] == MIDR) med_d = med_d | data_d[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N; j++) begin
        data_q[j] <= '0;
        rank_q[j] <= RW'(j);
      end
      tok_q      <= N'(1);
      out_valid  <= 1'b0;
      out_median <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int j = 0; j < N; j++) begin
          data_q[j] <= data_d[j];
          rank_q[j] <= rank_d[j];
        end
        tok_q      <= {tok_q[N-2:0], tok_q[N-1]};
        out_median <= med_d;
      end
    end
  end

  // R7: pointer stays one-hot, rotates on accept, holds otherwise
  a_r7_tok_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(tok_q) == 1);
  a_r7_tok_rotate: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> tok_q == {$past(tok_q[N-2:0]), $past(tok_q[N-1])});
  a_r5_tok_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(tok_q));

  // R2: valid delayed by one cycle
  a_r2_valid_hi: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_lo: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R5: median held on idle cycles
  a_r5_med_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_median));

  logic [N-1:0] rank_hit [N];
  always_comb begin
    for (int v = 0; v < N; v++)
      for (int j = 0; j < N; j++)
        rank_hit[v][j] = (rank_q[j] == RW'(v));
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R6: only the pointed slot may change
    a_r6_slot_fixed: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && tok_q[g]) |=> $stable(data_q[g]));
    // R4: ranks form a permutation
    a_r4_rank_perm: assert property (@(posedge clk) disable iff (rst)
      $countones(rank_hit[g]) == 1);
  end
endmodule

// File: tb/tokring_median_tb.sv
`timescale 1ns/1ps
module tokring_median_tb_top;
  localparam int N = 5;
  localparam int W = 3;
  localparam int MID = (N - 1) / 2;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [W-1:0] in_sample;
  logic out_valid;
  logic [W-1:0] out_median;

  int vectors = 0;
  int miscompares = 0;

  logic [W-1:0] win [N];
  int ptr = 0;
  logic exp_valid = 1'b0;
  logic [W-1:0] exp_med = '0;
  string cur_tag = "R3";

  always #5 clk = ~clk;

  tokring_median #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_median(out_median));

  function automatic logic [W-1:0] model_median();
    logic [W-1:0] s [N];
    logic [W-1:0] t;
    for (int i = 0; i < N; i++) s[i] = win[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    return s[MID];
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic [W-1:0] x);
    @(negedge clk);
    check("R2 out_valid", int'(out_valid), int'(exp_valid));
    check({cur_tag, " out_median"}, int'(out_median), int'(exp_med));
    in_valid  = v;
    in_sample = x;
    exp_valid = v;
    if (v) begin
      win[ptr] = x;
      ptr = (ptr + 1) % N;
      exp_med = model_median();
    end
  endtask

  initial begin
    #1500000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1;
    in_valid = 1'b0;
    in_sample = '0;
    for (int i = 0; i < N; i++) win[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", int'(out_valid), 0);
    check("R1 out_median reset", int'(out_median), 0);
    rst = 1'b0;

    // R1: window starts as zeros
    cur_tag = "R1";
    step(1'b1, 3'd7);
    step(1'b1, 3'd7);
    step(1'b1, 3'd7);

    // R4: constant stream, all ties
    cur_tag = "R4";
    for (int i = 0; i < 3 * N; i++) step(1'b1, 3'd5);

    // R7: monotonic streams wrap the pointer
    cur_tag = "R7";
    for (int i = 0; i < 24; i++) step(1'b1, W'(i));
    for (int i = 0; i < 24; i++) step(1'b1, W'(7 - (i % 8)));

    // R3 / R4 / R6: every triple of the alphabet
    cur_tag = "R3";
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          step(1'b1, W'(a));
          step(1'b1, W'(b));
          step(1'b1, W'(c));
        end

    // R5 / R6: pseudo-random stream with idle gaps
    cur_tag = "R5";
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:3] != 2'b00, lfsr[2:0]);
    end
    cur_tag = "R6";
    step(1'b0, 3'd0);
    step(1'b0, 3'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule